// File: doc/BRIEF.md
# Grid-Decomposed Single-Precision Multiplier

This block multiplies two 32-bit binary floating-point words and returns a 32-bit floating-point product three clock cycles later. The result sign is the exclusive-or of the operand signs. The result exponent is the sum of the biased operand exponents with one bias removed, and it is raised by one when the significand product reaches two or more. The 48-bit significand product is not formed by one wide multiplier. Each 24-bit significand (hidden one included) is cut into four 6-bit groups. The sixteen group-by-group products are placed at bit offset 6*(p+q) and summed.

Only zero and normal operands take part in arithmetic. An operand with a zero exponent field counts as zero, so denormals are flushed. An all-ones exponent field marks infinity (zero fraction) or NaN (nonzero fraction). The fraction is truncated, which gives round-toward-zero. An exponent that leaves the normal range saturates to a signed infinity or flushes to a signed zero. A valid flag travels with each operation, so a new pair can be issued on every cycle.

Top module: `sp_grid_mul`

## Requirements
- R1: For every result that is not NaN, the result sign bit (bit 31) equals the XOR of the operand sign bits.
- R2: For two normal operands whose product stays in range, the exponent field (bits 30:23) is Ea+Eb-127, plus one when the 48-bit significand product has bit 47 set. The fraction field (bits 22:0) then holds the product bits directly below the leading one.
- R3: The fraction is truncated. Product bits below the 23 kept fraction bits never raise the result, so 0x3F800001 x 0x3FC00000 gives 0x3FC00001.
- R4: When the adjusted exponent is 255 or more, the result is a signed infinity: exponent field all ones, fraction zero. An adjusted exponent of exactly 254 is kept as a normal result.
- R5: When the adjusted exponent is 0 or less, the result is a signed zero. The output never carries a zero exponent field with a nonzero fraction.
- R6: An operand with exponent field 0 counts as zero whatever its fraction. If the other operand is zero or normal, the result is a zero with the XOR sign.
- R7: If either operand is NaN, or infinity meets zero, the result is the quiet NaN 0x7FC00000. Infinity times a normal operand, or times infinity, gives an infinity with the XOR sign.
- R8: valid_o equals valid_i from three cycles earlier. Back-to-back operations leave in issue order, one per cycle. Reset clears valid_o and res_o to zero and drops any operation in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | a_i and b_i carry an operation this cycle |
| a_i | input | 32 | First operand, single-precision word |
| b_i | input | 32 | Second operand, single-precision word |
| valid_o | output | 1 | res_o carries a result this cycle |
| res_o | output | 32 | Product, single-precision word |

## Verification
The bench builds the block with its default parameters: an 8-bit exponent, a 23-bit fraction and four groups per significand. With these values exact 32-bit expected words can be worked out by hand. The chosen vectors land on the exponent limits 0, 1, 254 and 255. They include products on both sides of the bit-47 normalisation point and a case where truncation and round-to-nearest give different results. A stream of back-to-back operations and a reset applied mid-flight exercise the three-stage valid path.

// File: rtl/sp_grid_pkg.sv
package sp_grid_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } op_cls_e;
endpackage

// File: rtl/sp_grid_unpack.sv
module sp_grid_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1
) (
  input  logic [WORD_W-1:0]     op_i,
  output logic                  sgn_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [SIG_W-1:0]      sig_o,
  output sp_grid_pkg::op_cls_e  cls_o
);
  import sp_grid_pkg::*;

  logic [FRAC_W-1:0] frac;

  assign sgn_o = op_i[WORD_W-1];
  assign exp_o = op_i[WORD_W-2 -: EXP_W];
  assign frac  = op_i[FRAC_W-1:0];
  assign sig_o = {1'b1, frac};

  always_comb begin
    if (exp_o == '0)      cls_o = CLS_ZERO;  // denormals flushed
    else if (&exp_o)      cls_o = (frac == '0) ? CLS_INF : CLS_NAN;
    else                  cls_o = CLS_NORM;
  end
endmodule

// File: rtl/sp_grid_pp.sv
module sp_grid_pp #(
  parameter int SIG_W = 24,
  parameter int GRP_N = 4,
  localparam int GRP_W = SIG_W / GRP_N,
  localparam int PP_W  = 2 * GRP_W,
  localparam int NPP   = GRP_N * GRP_N
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [SIG_W-1:0]          sig_a_i,
  input  logic [SIG_W-1:0]          sig_b_i,
  output logic [NPP-1:0][PP_W-1:0]  pp_o
);
  for (genvar p = 0; p < GRP_N; p++) begin : g_a
    for (genvar q = 0; q < GRP_N; q++) begin : g_b
      logic [PP_W-1:0] grp_a, grp_b;
      assign grp_a = {{GRP_W{1'b0}}, sig_a_i[p*GRP_W +: GRP_W]};
      assign grp_b = {{GRP_W{1'b0}}, sig_b_i[q*GRP_W +: GRP_W]};

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   pp_o[p*GRP_N+q] <= '0;
        else if (en_i) pp_o[p*GRP_N+q] <= grp_a * grp_b;
      end
    end
  end
endmodule

// File: rtl/sp_grid_acc.sv
module sp_grid_acc #(
  parameter int SIG_W = 24,
  parameter int GRP_N = 4,
  localparam int GRP_W  = SIG_W / GRP_N,
  localparam int PP_W   = 2 * GRP_W,
  localparam int NPP    = GRP_N * GRP_N,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic [NPP-1:0][PP_W-1:0] pp_i,
  output logic [PROD_W-1:0]        prod_o
);
  // term (p,q) weighs 2^(GRP_W*(p+q))
  always_comb begin
    prod_o = '0;
    for (int p = 0; p < GRP_N; p++) begin
      for (int q = 0; q < GRP_N; q++) begin
        prod_o = prod_o + (PROD_W'(pp_i[p*GRP_N+q]) << (GRP_W*(p+q)));
      end
    end
  end
endmodule

// File: rtl/sp_grid_pack.sv
module sp_grid_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int SE_W   = EXP_W + 2,
  localparam int EXP_MAX = (1 << EXP_W) - 1
) (
  input  logic                     sgn_i,
  input  logic signed [SE_W-1:0]   exp_i,
  input  logic [PROD_W-1:0]        prod_i,
  input  sp_grid_pkg::op_cls_e     cls_a_i,
  input  sp_grid_pkg::op_cls_e     cls_b_i,
  output logic [WORD_W-1:0]        res_o
);
  import sp_grid_pkg::*;

  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic                   top;
  logic [FRAC_W-1:0]      frac;
  logic signed [SE_W-1:0] exp_n;
  logic any_nan, any_inf, any_zero;

  assign top   = prod_i[PROD_W-1];
  assign frac  = top ? prod_i[PROD_W-2 -: FRAC_W] : prod_i[PROD_W-3 -: FRAC_W];
  assign exp_n = exp_i + $signed({{(SE_W-1){1'b0}}, top});

  assign any_nan  = (cls_a_i == CLS_NAN)  || (cls_b_i == CLS_NAN);
  assign any_inf  = (cls_a_i == CLS_INF)  || (cls_b_i == CLS_INF);
  assign any_zero = (cls_a_i == CLS_ZERO) || (cls_b_i == CLS_ZERO);

  always_comb begin
    if (any_nan || (any_inf && any_zero))
      res_o = QNAN;
    else if (any_inf || exp_n >= $signed(SE_W'(EXP_MAX)))
      res_o = {sgn_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (any_zero || exp_n <= $signed(SE_W'(0)))
      res_o = {sgn_i, {(WORD_W-1){1'b0}}};
    else
      res_o = {sgn_i, exp_n[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/sp_grid_mul.sv
module sp_grid_mul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int GRP_N  = 4,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int GRP_W  = SIG_W / GRP_N,
  localparam int PP_W   = 2 * GRP_W,
  localparam int NPP    = GRP_N * GRP_N,
  localparam int PROD_W = 2 * SIG_W,
  localparam int SE_W   = EXP_W + 2,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] res_o
);
  import sp_grid_pkg::*;

  // operand decode
  logic             sgn_a, sgn_b;
  logic [EXP_W-1:0] exp_a, exp_b;
  logic [SIG_W-1:0] sig_a, sig_b;
  op_cls_e          cls_a, cls_b;

  sp_grid_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_a (
    .op_i(a_i), .sgn_o(sgn_a), .exp_o(exp_a), .sig_o(sig_a), .cls_o(cls_a)
  );
  sp_grid_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_b (
    .op_i(b_i), .sgn_o(sgn_b), .exp_o(exp_b), .sig_o(sig_b), .cls_o(cls_b)
  );

  logic signed [SE_W-1:0] exp_sum;
  assign exp_sum = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b}) - $signed(SE_W'(BIAS));

  // stage 1: group products
  logic [NPP-1:0][PP_W-1:0] s1_pp;
  logic                     s1_valid, s1_sgn;
  logic signed [SE_W-1:0]   s1_exp;
  op_cls_e                  s1_cls_a, s1_cls_b;

  sp_grid_pp #(.SIG_W(SIG_W), .GRP_N(GRP_N)) u_pp (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i),
    .sig_a_i(sig_a), .sig_b_i(sig_b), .pp_o(s1_pp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_sgn   <= 1'b0;
      s1_exp   <= '0;
      s1_cls_a <= CLS_ZERO;
      s1_cls_b <= CLS_ZERO;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_sgn   <= sgn_a ^ sgn_b;
        s1_exp   <= exp_sum;
        s1_cls_a <= cls_a;
        s1_cls_b <= cls_b;
      end
    end
  end

  // stage 2: shifted sum
  logic [PROD_W-1:0]      acc_prod, s2_prod;
  logic                   s2_valid, s2_sgn;
  logic signed [SE_W-1:0] s2_exp;
  op_cls_e                s2_cls_a, s2_cls_b;

  sp_grid_acc #(.SIG_W(SIG_W), .GRP_N(GRP_N)) u_acc (
    .pp_i(s1_pp), .prod_o(acc_prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_sgn   <= 1'b0;
      s2_exp   <= '0;
      s2_prod  <= '0;
      s2_cls_a <= CLS_ZERO;
      s2_cls_b <= CLS_ZERO;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_sgn   <= s1_sgn;
        s2_exp   <= s1_exp;
        s2_prod  <= acc_prod;
        s2_cls_a <= s1_cls_a;
        s2_cls_b <= s1_cls_b;
      end
    end
  end

  // stage 3: normalise, specials, pack
  logic [WORD_W-1:0] pack_res;

  sp_grid_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .sgn_i(s2_sgn), .exp_i(s2_exp), .prod_i(s2_prod),
    .cls_a_i(s2_cls_a), .cls_b_i(s2_cls_b), .res_o(pack_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= s2_valid;
      if (s2_valid) res_o <= pack_res;
    end
  end
endmodule

// File: rtl/sp_grid_mul_chk.sv
module sp_grid_mul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] res_o
);
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic a_nan, b_nan, a_zero, b_exp_max;
  assign a_nan     = (&a_i[WORD_W-2 -: EXP_W]) && (a_i[FRAC_W-1:0] != '0);
  assign b_nan     = (&b_i[WORD_W-2 -: EXP_W]) && (b_i[FRAC_W-1:0] != '0);
  assign a_zero    = (a_i[WORD_W-2 -: EXP_W] == '0);
  assign b_exp_max = &b_i[WORD_W-2 -: EXP_W];

  assert_valid_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  assert_sign_xor_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && valid_o && res_o != QNAN) |->
      (res_o[WORD_W-1] == $past(a_i[WORD_W-1] ^ b_i[WORD_W-1], 3)));

  assert_nan_in_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && valid_o && $past(valid_i && (a_nan || b_nan), 3)) |->
      (res_o == QNAN));

  assert_zero_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && valid_o && $past(valid_i && a_zero && !b_exp_max, 3)) |->
      (res_o[WORD_W-2:0] == '0));

  assert_no_bad_inf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (&res_o[WORD_W-2 -: EXP_W])) |->
      (res_o[FRAC_W-1:0] == '0 || res_o == QNAN));

  assert_no_denorm_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && res_o[WORD_W-2 -: EXP_W] == '0) |-> (res_o[FRAC_W-1:0] == '0));
endmodule

bind sp_grid_mul sp_grid_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
  .valid_o(valid_o), .res_o(res_o)
);

// File: tb/sp_grid_mul_bench.sv
`timescale 1ns/1ps
module sp_grid_mul_bench;
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] e;
    logic [7:0]  r;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    // R2: plain and bit-47 normalisation
    '{32'h3F800000, 32'h3F800000, 32'h3F800000, 8'd2},
    '{32'h3FC00000, 32'h3FC00000, 32'h40100000, 8'd2},
    '{32'h40000000, 32'h40400000, 32'h40C00000, 8'd2},
    // R1: signs
    '{32'hBF800000, 32'h40000000, 32'hC0000000, 8'd1},
    '{32'hC0400000, 32'hC0000000, 32'h40C00000, 8'd1},
    '{32'h3FC00000, 32'hBFC00000, 32'hC0100000, 8'd1},
    // R3: truncation
    '{32'h3F800001, 32'h3FC00000, 32'h3FC00001, 8'd3},
    '{32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 8'd3},
    // R4: overflow edge
    '{32'h7F000000, 32'h3F800000, 32'h7F000000, 8'd4},
    '{32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 8'd4},
    '{32'h7F000000, 32'h40000000, 32'h7F800000, 8'd4},
    '{32'hFF000000, 32'h7F000000, 32'hFF800000, 8'd4},
    // R5: underflow edge
    '{32'h00800000, 32'h3F800000, 32'h00800000, 8'd5},
    '{32'h00800000, 32'h3F000000, 32'h00000000, 8'd5},
    '{32'h80800000, 32'h3F000000, 32'h80000000, 8'd5},
    '{32'h00C00000, 32'h3F400000, 32'h00900000, 8'd5},
    '{32'h00C00000, 32'h3FC00000, 32'h01100000, 8'd5},
    // R6: zero and denormal operands
    '{32'h00000000, 32'h40400000, 32'h00000000, 8'd6},
    '{32'h80000000, 32'h40400000, 32'h80000000, 8'd6},
    '{32'h00000001, 32'h7F000000, 32'h00000000, 8'd6},
    '{32'h80400000, 32'h3F800000, 32'h80000000, 8'd6},
    '{32'h3F800000, 32'h807FFFFF, 32'h80000000, 8'd6},
    // R7: NaN and infinity
    '{32'h7FC00000, 32'h3F800000, 32'h7FC00000, 8'd7},
    '{32'h7F800001, 32'h00000000, 32'h7FC00000, 8'd7},
    '{32'hBF800000, 32'hFFFFFFFF, 32'h7FC00000, 8'd7},
    '{32'h7F800000, 32'hC0000000, 32'hFF800000, 8'd7},
    '{32'h7F800000, 32'h00000000, 32'h7FC00000, 8'd7},
    '{32'hFF800000, 32'h00000001, 32'h7FC00000, 8'd7},
    '{32'hFF800000, 32'hFF800000, 32'h7F800000, 8'd7},
    '{32'h00000000, 32'hFF800000, 32'h7FC00000, 8'd7}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [31:0] res_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  sp_grid_mul u_sp_grid_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  localparam logic [31:0] STREAM_A [4] = '{32'h3FC00000, 32'hC0400000, 32'h7F000000, 32'h00800000};
  localparam logic [31:0] STREAM_B [4] = '{32'h3FC00000, 32'h40000000, 32'h40000000, 32'h3F000000};
  localparam logic [31:0] STREAM_E [4] = '{32'h40100000, 32'hC0C00000, 32'h7F800000, 32'h00000000};

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk("R8 reset valid", {31'd0, valid_o}, 32'd0);
    chk("R8 reset data", res_o, 32'd0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R8: idle operands with valid low produce nothing
    a_i = 32'h40000000;
    b_i = 32'h40000000;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      chk("R8 idle valid", {31'd0, valid_o}, 32'd0);
    end

    // vector table, one operation at a time
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      a_i = VEC[i].a;
      b_i = VEC[i].b;
      valid_i = 1'b1;
      @(posedge clk_i);
      #1 valid_i = 1'b0;
      repeat (2) @(posedge clk_i);
      #1;
      chk($sformatf("R%0d vec %0d", VEC[i].r, i), res_o, VEC[i].e);
      chk("R8 single valid", {31'd0, valid_o}, 32'd1);
      @(posedge clk_i);
      #1;
      chk("R8 single drop", {31'd0, valid_o}, 32'd0);
    end

    // R8: back-to-back stream keeps order, one result per cycle
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      if (k >= 3 && k < 7) begin
        chk("R8 stream data", res_o, STREAM_E[k-3]);
        chk("R8 stream valid", {31'd0, valid_o}, 32'd1);
      end
      if (k == 7) chk("R8 stream end", {31'd0, valid_o}, 32'd0);
      if (k < 4) begin
        a_i = STREAM_A[k];
        b_i = STREAM_B[k];
        valid_i = 1'b1;
      end else begin
        valid_i = 1'b0;
      end
    end

    // R8: reset mid-flight drops the operation
    @(negedge clk_i);
    a_i = 32'h3F800000;
    b_i = 32'h40000000;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk("R8 flush valid", {31'd0, valid_o}, 32'd0);
    end
    chk("R8 flush data", res_o, 32'd0);

    finish_run();
  end
endmodule